// File: doc/BRIEF.md
# Peripheral Interrupt Status Controller

This block gathers four serial-port event sources and turns them into four level-sensitive interrupt lines, one per source. Each source has a sticky state bit. A one-cycle pulse from the event logic sets the bit. The bit stays set until software clears it. An enable bit per source gates the state bit onto its interrupt line.

Software reaches the block over a plain 32-bit register port. That port has a write strobe, a read strobe and a byte address, and the address is decoded on word boundaries. There are three registers:

- **State** (word 0): reads the sticky bits. Writing a 1 clears the matching bit.
- **Enable** (word 1): read/write mask that gates each state bit onto its line.
- **Force** (word 2): write-only. A write ORs the written value into the state bits, so software can raise any interrupt for testing.

Bit 0 is TX watermark, bit 1 is RX watermark, bit 2 is TX empty and bit 3 is RX overflow. The reset input is asserted asynchronously. Its release is synchronised to the clock, so the registers leave reset two clock edges after the input goes high.

Top module: `irq_status_ctrl`

## Requirements
- R1: There are four sources with fixed bit positions in every register and on the interrupt vector: bit 0 TX watermark, bit 1 RX watermark, bit 2 TX empty, bit 3 RX overflow.
- R2: In every cycle, interrupt line i is 1 exactly when state bit i and enable bit i are both 1.
- R3: A 1 on hw_set_i[i] at a clock edge sets state bit i. The bit then stays 1 until software clears it.
- R4: A write to word 0 clears each state bit whose write-data bit is 1 and leaves every other state bit unchanged.
- R5: When a set pulse and a write-1 clear reach the same state bit at the same edge, the bit ends up 1.
- R6: A write to word 2 ORs write-data bits 3:0 into the state bits.
- R7: A read of word 2 returns zero.
- R8: A write to word 1 replaces all four enable bits with write-data bits 3:0. A read of word 1 returns the stored enable bits.
- R9: While reset is asserted, and after it is released, the state bits, the enable bits and all interrupt lines are 0.
- R10: Read-data bits 31:4 are always 0. Reading any word index above 2 returns 0, writing one changes nothing, and reg_rdata_o is 0 whenever reg_re_i is 0.
- R11: Only reg_addr_i[ADDR_W-1:2] selects the register. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_re_i | input | 1 | Read strobe; read data is valid in the same cycle |
| reg_addr_i | input | ADDR_W (10) | Byte address; bits ADDR_W-1:2 select the word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, zero when no read is strobed |
| hw_set_i | input | 4 | Event pulses from the serial-port logic, one bit per source |
| irq_o | output | 4 | Level interrupt lines, one bit per source |

## Verification
The assertions assume that reg_we_i and reg_re_i are never X after reset. They also assume that a write strobe lasts exactly one cycle per intended write, because a strobe held high is taken as repeated writes. The stimulus drives every input at the falling edge from a task that sets all of them at once, so no strobe is left floating or held over by accident. The stimulus keeps hw_set_i at zero while reset is being released, so no event is lost during the two-edge synchronisation window.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 32;

  localparam int SRC_TX_WMARK = 0;
  localparam int SRC_RX_WMARK = 1;
  localparam int SRC_TX_EMPTY = 2;
  localparam int SRC_RX_OVFL  = 3;

  localparam int WORD_STATE  = 0;
  localparam int WORD_ENABLE = 1;
  localparam int WORD_FORCE  = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_state_o,
  output logic              wr_enable_o,
  output logic              wr_force_o
);
  logic unused_byte_lanes;
  assign unused_byte_lanes = ^addr_i[1:0];

  always_comb begin
    word_o      = addr_i[ADDR_W-1:2];
    wr_state_o  = we_i && (word_o == WORD_W'(WORD_STATE));
    wr_enable_o = we_i && (word_o == WORD_W'(WORD_ENABLE));
    wr_force_o  = we_i && (word_o == WORD_W'(WORD_FORCE));
  end
endmodule

// File: rtl/irq_state_cell.sv
module irq_state_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic sw_clr_i,
  input  logic sw_force_i,
  output logic state_o
);
  logic state_q;
  logic state_d;
  logic state_en;

  always_comb begin
    state_en = hw_set_i | sw_clr_i | sw_force_i;
    state_d  = hw_set_i | sw_force_i | (state_q & ~sw_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= 1'b0;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_SRC-1:0] hw_set_i,
  output logic [NUM_SRC-1:0] irq_o
);
  logic        rst_sync_n;
  logic [WORD_W-1:0] word;
  logic        wr_state, wr_enable, wr_force;
  src_vec_t    state_q;
  src_vec_t    en_q;
  src_vec_t    en_d;
  logic        unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_SRC];

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .word_o      (word),
    .wr_state_o  (wr_state),
    .wr_enable_o (wr_enable),
    .wr_force_o  (wr_force)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_state_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .hw_set_i   (hw_set_i[i]),
      .sw_clr_i   (wr_state & reg_wdata_i[i]),
      .sw_force_i (wr_force & reg_wdata_i[i]),
      .state_o    (state_q[i])
    );
  end

  always_comb begin
    en_d = reg_wdata_i[NUM_SRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)    en_q <= '0;
    else if (wr_enable) en_q <= en_d;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      if (word == WORD_W'(WORD_STATE))       reg_rdata_o[NUM_SRC-1:0] = state_q;
      else if (word == WORD_W'(WORD_ENABLE)) reg_rdata_o[NUM_SRC-1:0] = en_q;
    end
  end

  assign irq_o = state_q & en_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_SRC-1:0] hw_set_i,
  input  logic [NUM_SRC-1:0] irq_o,
  input  logic [NUM_SRC-1:0] state_q,
  input  logic [NUM_SRC-1:0] en_q
);
  logic [WORD_W-1:0] c_word;
  logic [NUM_SRC-1:0] c_wd;
  assign c_word = reg_addr_i[ADDR_W-1:2];
  assign c_wd   = reg_wdata_i[NUM_SRC-1:0];

  assert_set_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hw_set_i != '0) |=> ((state_q & $past(hw_set_i)) == $past(hw_set_i)));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && c_word == WORD_W'(WORD_STATE) && hw_set_i == '0)
      |=> ((state_q & $past(c_wd)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && c_word == WORD_W'(WORD_STATE) && (hw_set_i & c_wd) != '0)
      |=> ((state_q & $past(hw_set_i & c_wd)) == $past(hw_set_i & c_wd)));

  assert_force_or_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && c_word == WORD_W'(WORD_FORCE))
      |=> ((state_q & $past(c_wd)) == $past(c_wd)));

  assert_force_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_re_i && c_word == WORD_W'(WORD_FORCE)) |-> (reg_rdata_o == '0));

  assert_enable_write_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && c_word == WORD_W'(WORD_ENABLE)) |=> (en_q == $past(c_wd)));

  assert_irq_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!reg_we_i && hw_set_i == '0) |=> $stable(irq_o));

  assert_upper_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    reg_rdata_o[DATA_W-1:NUM_SRC] == '0);
endmodule

bind irq_status_ctrl irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .hw_set_i    (hw_set_i),
  .irq_o       (irq_o),
  .state_q     (state_q),
  .en_q        (en_q)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  localparam int AW = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        reg_we_i, reg_re_i;
  logic [AW-1:0] reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [3:0]  hw_set_i;
  logic [3:0]  irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] m_state = '0;
  logic [3:0] m_en    = '0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_status_ctrl #(.ADDR_W(AW)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .reg_we_i (reg_we_i), .reg_re_i (reg_re_i),
    .reg_addr_i (reg_addr_i), .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .hw_set_i (hw_set_i), .irq_o (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic re, input logic [AW-1:0] a);
    int w = int'(a[AW-1:2]);
    if (!re) return 32'h0;
    if (w == 0) return {28'h0, m_state};
    if (w == 1) return {28'h0, m_en};
    return 32'h0;
  endfunction

  // One clock: drive at falling edge, compare, advance the model at the rising edge.
  task automatic cycle(input logic we, input logic re, input logic [AW-1:0] a,
                       input logic [31:0] wd, input logic [3:0] set, input string tag);
    int w;
    reg_we_i = we; reg_re_i = re; reg_addr_i = a; reg_wdata_i = wd; hw_set_i = set;
    #1;
    check({tag, " R2 irq"}, {28'h0, irq_o}, {28'h0, m_state & m_en});
    check({tag, " rdata"}, reg_rdata_o, model_read(re, a));
    @(posedge clk_i);
    w = int'(a[AW-1:2]);
    if (we && w == 0) m_state = m_state & ~wd[3:0];
    if (we && w == 2) m_state = m_state | wd[3:0];
    m_state = m_state | set;
    if (we && w == 1) m_en = wd[3:0];
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cycle(1'b0, 1'b1, a, 32'h0, 4'h0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    cycle(1'b1, 1'b0, a, d, 4'h0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    reg_we_i = 0; reg_re_i = 0; reg_addr_i = '0; reg_wdata_i = '0; hw_set_i = '0;
    repeat (3) @(negedge clk_i);
    // R9: reset values, reads and lines all zero while held
    reg_re_i = 1'b1; reg_addr_i = 10'h000; #1;
    check("R9 state in reset", reg_rdata_o, 32'h0);
    reg_addr_i = 10'h004; #1;
    check("R9 enable in reset", reg_rdata_o, 32'h0);
    check("R9 irq in reset", {28'h0, irq_o}, 32'h0);
    reg_re_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    rd(10'h000, "R9 state after reset");
    rd(10'h004, "R9 enable after reset");

    // R1, R3: each event sets its own bit position; sticky afterwards
    for (int i = 0; i < 4; i++) begin
      cycle(1'b0, 1'b0, '0, '0, 4'(1 << i), "R3 set");
      rd(10'h000, "R1 R3 bit position");
      wr(10'h000, 32'h0000000F, "R4 clear all");
    end
    cycle(1'b0, 1'b0, '0, '0, 4'b0100, "R3 pulse");
    repeat (3) rd(10'h000, "R3 sticky");

    // R8, R2: enable overwrite and gating
    wr(10'h004, 32'h0000000F, "R8 enable all");
    rd(10'h004, "R8 readback");
    wr(10'h004, 32'h00000005, "R8 overwrite");
    rd(10'h004, "R8 readback 5");
    cycle(1'b0, 1'b0, '0, '0, 4'b1010, "R2 masked sources");
    rd(10'h000, "R2 state 1110");

    // R4: clear one bit leaves others
    wr(10'h000, 32'h00000002, "R4 clear bit1");
    rd(10'h000, "R4 others kept");
    wr(10'h000, 32'h00000000, "R4 zero write");
    rd(10'h000, "R4 no change");

    // R5: set and clear together
    cycle(1'b1, 1'b0, 10'h000, 32'h0000000C, 4'b1000, "R5 set vs clear");
    rd(10'h000, "R5 set wins");

    // R6, R7: force register
    wr(10'h000, 32'h0000000F, "R4 clear");
    wr(10'h008, 32'h00000009, "R6 force");
    rd(10'h000, "R6 ored in");
    wr(10'h008, 32'h00000002, "R6 force more");
    rd(10'h000, "R6 accumulate");
    rd(10'h008, "R7 force reads zero");

    // R10: upper bits, undefined words
    wr(10'h004, 32'hFFFFFFF3, "R10 upper bits");
    rd(10'h004, "R10 upper read zero");
    wr(10'h00C, 32'h0000000F, "R10 undefined write");
    rd(10'h000, "R10 state unchanged");
    rd(10'h004, "R10 enable unchanged");
    rd(10'h3FC, "R10 undefined read");
    cycle(1'b0, 1'b0, 10'h000, 32'h0, 4'h0, "R10 no strobe");

    // R11: byte lane bits ignored
    wr(10'h007, 32'h0000000A, "R11 enable via 0x7");
    rd(10'h005, "R11 read via 0x5");
    wr(10'h002, 32'h00000001, "R11 clear via 0x2");
    rd(10'h003, "R11 state via 0x3");

    // Mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [1:0] w2 = 2'($urandom_range(0, 3));
      cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            {6'h0, w2, 2'($urandom_range(0, 3))}, $urandom,
            4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)), "R2 R3 R4 mixed");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule